// File: doc/BRIEF.md
# Idle-Timeout Power Ladder Controller

This block decides the power state of one component that can go idle. It watches two inputs that mean "work is present": an activity strobe from the component and a request line from its user. While neither is asserted, an idle counter runs. When the counter reaches the timeout of the next deeper state, the controller steps the component one rung down a ladder of four states: Work, then Sleep, then Deep, then Off. Each step costs a programmed number of shutdown cycles. Each deeper state has its own timeout, and that timeout is counted from the moment the previous state was reached.

A descent only pays off if the component stays idle longer than the cost of going down and coming back up. For this reason the block never uses a timeout shorter than the state's break-even time, which is its shutdown count plus its wakeup count. If a request or activity arrives while the component is in a low-power state, the controller runs that state's wakeup count and then returns to Work. If the request arrives in the middle of a shutdown, the shutdown finishes first and the wakeup follows on the next edge. A ready output tells the requester when the component can take work. One-hot enable outputs and a 2-bit code report the current state to the power switches.

Top module: `pwr_ladder_ctrl`

## Requirements
- R1: A synchronous active-high reset places the controller resident in Work: state_o = 0, ready_o = 1, transit_o = 0, state_en_o = 4'b0001.
- R2: state_o codes the reported state as Work = 0, Sleep = 1, Deep = 2, Off = 3. state_en_o is one-hot, and bit k is set exactly when state_o = k.
- R3: ready_o is high only while the controller is resident in Work. Suppose activity_i and request_i stay low for T consecutive clock edges while resident in Work, where T is the effective Sleep timeout. At the T-th edge the controller enters shutdown: transit_o rises and ready_o falls.
- R4: Configuration slice 0 belongs to Sleep, slice 1 to Deep and slice 2 to Off. A shutdown or wakeup count of 0 is treated as 1. The effective timeout of a state is the larger of its programmed timeout and its break-even time, where break-even time = effective shutdown count + effective wakeup count.
- R5: A shutdown into state S lasts S's effective shutdown count in edges. state_o keeps the shallower state until the last of those edges, then reports S with transit_o low.
- R6: The timeouts of Deep and Off are counted from the edge at which Sleep or Deep, respectively, was reached.
- R7: Activity or a request while resident in Work clears the idle count and keeps ready_o high. The next descent needs a full timeout after the last such edge.
- R8: A request or activity sampled while resident in Sleep, Deep or Off raises transit_o and keeps ready_o low from that edge. state_o keeps the low-power code until that state's effective wakeup count of edges has passed. At that edge state_o becomes 0 and ready_o becomes 1.
- R9: A request sampled during a shutdown does not cut the shutdown short. The deeper state is reached on schedule, and the wakeup of that deeper state starts at the same edge.
- R10: Off is the last rung. While resident in Off with no activity or request, the controller stays in Off with transit_o low for any length of time.
- R11: Activity or a request during a wakeup has no effect on it. The wakeup neither restarts nor lengthens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| activity_i | input | 1 | Component reports it is doing work |
| request_i | input | 1 | Requester wants the component |
| timeout_cfg_i | input | 3 x CNT_W | Idle timeout per low-power state (slice 0 Sleep, 1 Deep, 2 Off) |
| shutdown_cfg_i | input | 3 x CNT_W | Shutdown cycle count per low-power state |
| wakeup_cfg_i | input | 3 x CNT_W | Wakeup cycle count per low-power state |
| ready_o | output | 1 | Component is in Work and can accept requests |
| state_o | output | 2 | Current state code (0 Work, 1 Sleep, 2 Deep, 3 Off) |
| state_en_o | output | 4 | One-hot enable of the current state |
| transit_o | output | 1 | A shutdown or wakeup is in progress |

## Verification
The descent is tried with a set of Sleep configurations. In some, the programmed timeout is above break-even. In others it is below break-even, and one uses all-zero counts. Comparing the edge of the first shutdown with the edge of Sleep entry tells clamping apart from the raw timeout, and shutdown time apart from idle time. Periodic activity pulses shorter than the timeout show whether the idle count is cleared or merely paused. A full walk down to Off is followed by a wakeup with the request held. A request is injected in the middle of a Deep shutdown, and Deep has a different wakeup count from Sleep, so the bench can see which wakeup count the controller applies and whether the shutdown was cut short.

// File: rtl/pwr_ladder_pkg.sv
`timescale 1ns/1ps
package pwr_ladder_pkg;

    // number of low-power rungs below Work
    localparam int PL_NLP = 3;
    // default counter width for configuration fields
    localparam int PL_CW_DEF = 16;

    typedef enum logic [1:0] {
        PL_WORK  = 2'd0,
        PL_SLEEP = 2'd1,
        PL_DEEP  = 2'd2,
        PL_OFF   = 2'd3
    } pl_level_e;

    typedef enum logic [1:0] {
        PH_RESIDE = 2'd0,
        PH_DOWN   = 2'd1,
        PH_UP     = 2'd2
    } pl_phase_e;

    typedef struct packed {
        pl_phase_e phase;
        pl_level_e level;
        logic      pend;   // wake seen while a shutdown runs
    } pl_seq_t;

    // transition counts of zero still take one cycle
    function automatic int unsigned pl_floor1(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int unsigned pl_break_even(input int unsigned sd,
                                                  input int unsigned wu);
        return pl_floor1(sd) + pl_floor1(wu);
    endfunction

    function automatic int unsigned pl_clamp_timeout(input int unsigned tmo,
                                                     input int unsigned be);
        return (tmo > be) ? tmo : be;
    endfunction

    function automatic pl_level_e pl_deeper(input pl_level_e l);
        pl_level_e r;
        case (l)
            PL_WORK:  r = PL_SLEEP;
            PL_SLEEP: r = PL_DEEP;
            default:  r = PL_OFF;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pl_budget.sv
`timescale 1ns/1ps
// Turns raw per-state configuration into effective cycle budgets.
module pl_budget
    import pwr_ladder_pkg::*;
#(
    parameter int CNT_W = PL_CW_DEF,
    parameter int CTR_W = CNT_W + 1
) (
    input  logic [PL_NLP-1:0][CNT_W-1:0] tmo_i,
    input  logic [PL_NLP-1:0][CNT_W-1:0] sd_i,
    input  logic [PL_NLP-1:0][CNT_W-1:0] wu_i,
    output logic [PL_NLP-1:0][CTR_W-1:0] eff_tmo_o,
    output logic [PL_NLP-1:0][CTR_W-1:0] eff_sd_o,
    output logic [PL_NLP-1:0][CTR_W-1:0] eff_wu_o
);

    for (genvar k = 0; k < PL_NLP; k++) begin : g_rung
        int unsigned be;
        always_comb begin
            be           = pl_break_even(32'(sd_i[k]), 32'(wu_i[k]));
            eff_sd_o[k]  = CTR_W'(pl_floor1(32'(sd_i[k])));
            eff_wu_o[k]  = CTR_W'(pl_floor1(32'(wu_i[k])));
            eff_tmo_o[k] = CTR_W'(pl_clamp_timeout(32'(tmo_i[k]), be));
        end
    end

endmodule

// File: rtl/pl_seq.sv
`timescale 1ns/1ps
// Ladder sequencer: one shared counter serves idle, shutdown and wakeup.
module pl_seq
    import pwr_ladder_pkg::*;
#(
    parameter int CTR_W = PL_CW_DEF + 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wake_i,
    input  logic [PL_NLP-1:0][CTR_W-1:0] eff_tmo_i,
    input  logic [PL_NLP-1:0][CTR_W-1:0] eff_sd_i,
    input  logic [PL_NLP-1:0][CTR_W-1:0] eff_wu_i,
    output pl_seq_t                      st_o
);

    pl_seq_t          st;
    logic [CTR_W-1:0] cnt;
    logic [CTR_W-1:0] lim;
    logic             at_lim;

    // budget of the phase currently running
    always_comb begin
        lim = '1;
        unique case (st.phase)
            PH_RESIDE, PH_DOWN: begin
                // rung index of the next deeper state equals current level
                unique case (st.level)
                    PL_WORK:  lim = (st.phase == PH_DOWN) ? eff_sd_i[0] : eff_tmo_i[0];
                    PL_SLEEP: lim = (st.phase == PH_DOWN) ? eff_sd_i[1] : eff_tmo_i[1];
                    PL_DEEP:  lim = (st.phase == PH_DOWN) ? eff_sd_i[2] : eff_tmo_i[2];
                    default:  lim = '1;
                endcase
            end
            PH_UP: begin
                unique case (st.level)
                    PL_SLEEP: lim = eff_wu_i[0];
                    PL_DEEP:  lim = eff_wu_i[1];
                    PL_OFF:   lim = eff_wu_i[2];
                    default:  lim = eff_wu_i[0];
                endcase
            end
            default: lim = '1;
        endcase
    end

    assign at_lim = (cnt == lim - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '{phase: PH_RESIDE, level: PL_WORK, pend: 1'b0};
            cnt <= '0;
        end else begin
            unique case (st.phase)
                PH_RESIDE: begin
                    if (wake_i) begin
                        cnt <= '0;
                        if (st.level != PL_WORK) begin
                            st.phase <= PH_UP;
                        end
                    end else if (st.level != PL_OFF) begin
                        if (at_lim) begin
                            st.phase <= PH_DOWN;
                            st.pend  <= 1'b0;
                            cnt      <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_DOWN: begin
                    if (at_lim) begin
                        st.level <= pl_deeper(st.level);
                        st.phase <= (wake_i || st.pend) ? PH_UP : PH_RESIDE;
                        st.pend  <= 1'b0;
                        cnt      <= '0;
                    end else begin
                        st.pend <= st.pend | wake_i;
                        cnt     <= cnt + 1'b1;
                    end
                end
                PH_UP: begin
                    if (at_lim) begin
                        st.level <= PL_WORK;
                        st.phase <= PH_RESIDE;
                        cnt      <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    st.phase <= PH_RESIDE;
                    cnt      <= '0;
                end
            endcase
        end
    end

    assign st_o = st;

endmodule

// File: rtl/pl_outdec.sv
`timescale 1ns/1ps
// Decodes the sequencer state into the block's status and enables.
module pl_outdec
    import pwr_ladder_pkg::*;
#(
    parameter int NST = PL_NLP + 1
) (
    input  pl_seq_t        st_i,
    output logic [1:0]     state_o,
    output logic [NST-1:0] state_en_o,
    output logic           ready_o,
    output logic           transit_o
);

    assign state_o   = st_i.level;
    assign transit_o = (st_i.phase != PH_RESIDE);
    assign ready_o   = (st_i.phase == PH_RESIDE) && (st_i.level == PL_WORK);

    for (genvar g = 0; g < NST; g++) begin : g_en
        assign state_en_o[g] = (st_i.level == 2'(g));
    end

endmodule

// File: rtl/pwr_ladder_ctrl.sv
`timescale 1ns/1ps
module pwr_ladder_ctrl
    import pwr_ladder_pkg::*;
#(
    parameter int CNT_W = PL_CW_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         activity_i,
    input  logic                         request_i,
    input  logic [PL_NLP-1:0][CNT_W-1:0] timeout_cfg_i,
    input  logic [PL_NLP-1:0][CNT_W-1:0] shutdown_cfg_i,
    input  logic [PL_NLP-1:0][CNT_W-1:0] wakeup_cfg_i,
    output logic                         ready_o,
    output logic [1:0]                   state_o,
    output logic [PL_NLP:0]              state_en_o,
    output logic                         transit_o
);

    localparam int CTR_W = CNT_W + 1;

    logic [PL_NLP-1:0][CTR_W-1:0] eff_tmo;
    logic [PL_NLP-1:0][CTR_W-1:0] eff_sd;
    logic [PL_NLP-1:0][CTR_W-1:0] eff_wu;
    pl_seq_t                      seq_st;
    logic                         wake;

    assign wake = activity_i | request_i;

    pl_budget #(.CNT_W(CNT_W), .CTR_W(CTR_W)) u_budget (
        .tmo_i     (timeout_cfg_i),
        .sd_i      (shutdown_cfg_i),
        .wu_i      (wakeup_cfg_i),
        .eff_tmo_o (eff_tmo),
        .eff_sd_o  (eff_sd),
        .eff_wu_o  (eff_wu)
    );

    pl_seq #(.CTR_W(CTR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wake_i    (wake),
        .eff_tmo_i (eff_tmo),
        .eff_sd_i  (eff_sd),
        .eff_wu_i  (eff_wu),
        .st_o      (seq_st)
    );

    pl_outdec #(.NST(PL_NLP + 1)) u_dec (
        .st_i       (seq_st),
        .state_o    (state_o),
        .state_en_o (state_en_o),
        .ready_o    (ready_o),
        .transit_o  (transit_o)
    );

endmodule

// File: rtl/pwr_ladder_chk.sv
`timescale 1ns/1ps
module pwr_ladder_chk (
    input logic       clk,
    input logic       rst,
    input logic       activity_i,
    input logic       request_i,
    input logic       ready_o,
    input logic [1:0] state_o,
    input logic [3:0] state_en_o,
    input logic       transit_o
);

    logic wake;
    assign wake = activity_i | request_i;

    a_r1_reset_work: assert property (@(posedge clk)
        $past(rst) |-> (state_o == 2'd0 && ready_o && !transit_o));

    a_r2_en_matches: assert property (@(posedge clk) disable iff (rst)
        ($countones(state_en_o) == 1) && state_en_o[state_o]);

    a_r3_ready_only_work: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (state_o == 2'd0 && !transit_o));

    a_r5_step_order: assert property (@(posedge clk) disable iff (rst)
        (state_o != $past(state_o)) |->
            (state_o == $past(state_o) + 2'd1 || state_o == 2'd0));

    a_r7_work_stays_ready: assert property (@(posedge clk) disable iff (rst)
        (ready_o && wake) |=> ready_o);

    a_r8_wake_starts: assert property (@(posedge clk) disable iff (rst)
        (!transit_o && state_o != 2'd0 && wake) |=> (transit_o && !ready_o));

    a_r10_off_holds: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd3 && !transit_o && !wake) |=> (state_o == 2'd3 && !transit_o));

endmodule

bind pwr_ladder_ctrl pwr_ladder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .activity_i (activity_i),
    .request_i  (request_i),
    .ready_o    (ready_o),
    .state_o    (state_o),
    .state_en_o (state_en_o),
    .transit_o  (transit_o)
);

// File: tb/pwr_ladder_ctrl_test.sv
`timescale 1ns/1ps
module pwr_ladder_ctrl_test;

    localparam int CW = 16;
    localparam int NROW = 5;
    // timeout, shutdown, wakeup for Sleep; expected edge of shutdown start,
    // edge of Sleep entry, edges from sampled request to ready
    localparam int VEC [0:NROW-1][0:5] = '{
        '{10, 2, 3, 10, 12, 3},
        '{ 3, 2, 4,  6,  8, 4},
        '{ 0, 0, 0,  2,  3, 1},
        '{ 7, 1, 6,  7,  8, 6},
        '{20, 5, 2, 20, 25, 2}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic act = 1'b0;
    logic req = 1'b0;
    logic [2:0][CW-1:0] tmo;
    logic [2:0][CW-1:0] sd;
    logic [2:0][CW-1:0] wu;
    logic       ready;
    logic [1:0] st;
    logic [3:0] en;
    logic       tr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pwr_ladder_ctrl #(.CNT_W(CW)) uut (
        .clk            (clk),
        .rst            (rst),
        .activity_i     (act),
        .request_i      (req),
        .timeout_cfg_i  (tmo),
        .shutdown_cfg_i (sd),
        .wakeup_cfg_i   (wu),
        .ready_o        (ready),
        .state_o        (st),
        .state_en_o     (en),
        .transit_o      (tr)
    );

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input int actual, input int expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic do_reset;
        rst = 1'b1;
        act = 1'b0;
        req = 1'b0;
        tick;
        tick;
        rst = 1'b0;
    endtask

    task automatic chain_cfg;
        tmo[0] = 16'd4; sd[0] = 16'd1; wu[0] = 16'd1;
        tmo[1] = 16'd6; sd[1] = 16'd2; wu[1] = 16'd2;
        tmo[2] = 16'd5; sd[2] = 16'd3; wu[2] = 16'd3;
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog (all requirements): actual hung expected completion");
        report();
        $finish;
    end

    initial begin
        int down_at;
        int sleep_at;
        int wake_len;
        int low_seen;
        int gap;

        // R1 / R2: reset state
        chain_cfg();
        do_reset();
        chk("R1 state after reset", int'(st), 0);
        chk("R1 ready after reset", int'(ready), 1);
        chk("R1 transit after reset", int'(tr), 0);
        chk("R2 enable after reset", int'(en), 1);

        // R3 R4 R5 R8: table of Sleep configurations
        for (int i = 0; i < NROW; i++) begin
            tmo[0] = CW'(VEC[i][0]); sd[0] = CW'(VEC[i][1]); wu[0] = CW'(VEC[i][2]);
            tmo[1] = 16'd1000; sd[1] = 16'd50; wu[1] = 16'd50;
            tmo[2] = 16'd1000; sd[2] = 16'd50; wu[2] = 16'd50;
            do_reset();
            down_at = 0;
            sleep_at = 0;
            for (int k = 1; k <= 200; k++) begin
                tick;
                if (tr && down_at == 0) down_at = k;
                if (st == 2'd1 && !tr) begin
                    sleep_at = k;
                    break;
                end
            end
            chk($sformatf("R3/R4 row %0d shutdown start edge", i), down_at, VEC[i][3]);
            chk($sformatf("R5 row %0d Sleep entry edge", i), sleep_at, VEC[i][4]);
            chk($sformatf("R2 row %0d Sleep enable", i), int'(en), 2);
            req = 1'b1;
            tick;
            req = 1'b0;
            chk($sformatf("R8 row %0d transit after request", i), int'(tr), 1);
            wake_len = 0;
            for (int m = 1; m <= 200; m++) begin
                tick;
                if (ready) begin
                    wake_len = m;
                    break;
                end
            end
            chk($sformatf("R8 row %0d wakeup length", i), wake_len, VEC[i][5]);
            chk($sformatf("R8 row %0d state after wakeup", i), int'(st), 0);
        end

        // R7: activity pulses shorter than the timeout clear the idle count
        tmo[0] = 16'd10; sd[0] = 16'd2; wu[0] = 16'd3;
        do_reset();
        low_seen = 0;
        for (int k = 1; k <= 40; k++) begin
            act = (k % 8 == 0);
            tick;
            if (!ready || tr) low_seen++;
        end
        act = 1'b0;
        chk("R7 ready held across activity", low_seen, 0);
        gap = 0;
        for (int k = 1; k <= 100; k++) begin
            tick;
            if (tr) begin
                gap = k;
                break;
            end
        end
        chk("R7 full timeout after last activity", gap, 10);

        // R6 R5 R10: full ladder down to Off
        chain_cfg();
        do_reset();
        for (int n = 1; n <= 60; n++) begin
            tick;
            if (n == 5)  begin chk("R5 Sleep at edge 5", int'(st), 1); chk("R5 settled at 5", int'(tr), 0); end
            if (n == 12) begin chk("R6 still Sleep at 12", int'(st), 1); chk("R6 Deep shutdown at 12", int'(tr), 1); end
            if (n == 13) chk("R6 Deep at edge 13", int'(st), 2);
            if (n == 21) begin chk("R4 Off clamp: Deep at 21", int'(st), 2); chk("R6 Off shutdown at 21", int'(tr), 1); end
            if (n == 22) chk("R6 Off at edge 22", int'(st), 3);
        end
        chk("R10 Off held", int'(st), 3);
        chk("R10 no transit in Off", int'(tr), 0);
        chk("R2 Off enable", int'(en), 8);

        // R8 R11: wake from Off with request held through the wakeup
        req = 1'b1;
        tick;
        tick;
        chk("R11 m1 state", int'(st), 3);
        chk("R11 m1 ready", int'(ready), 0);
        tick;
        chk("R11 m2 state", int'(st), 3);
        chk("R11 m2 ready", int'(ready), 0);
        tick;
        chk("R8 Off wakeup done state", int'(st), 0);
        chk("R8 Off wakeup done ready", int'(ready), 1);
        tick;
        chk("R7 request in Work keeps ready", int'(ready), 1);
        req = 1'b0;

        // R9: request during the Deep shutdown
        chain_cfg();
        do_reset();
        for (int n = 1; n <= 11; n++) tick;
        chk("R9 Deep shutdown begun", int'(tr), 1);
        req = 1'b1;
        tick;
        req = 1'b0;
        chk("R9 shutdown not cut short", int'(st), 1);
        tick;
        chk("R9 Deep reached", int'(st), 2);
        chk("R9 wakeup started", int'(tr), 1);
        chk("R9 not ready yet", int'(ready), 0);
        tick;
        chk("R9 Deep wakeup still running", int'(ready), 0);
        tick;
        chk("R9 ready after Deep wakeup", int'(ready), 1);
        chk("R9 back in Work", int'(st), 0);

        report();
        $finish;
    end

endmodule